// File: doc/BRIEF.md
# Per-Row Tentative Run Labeler

This block gives every run of a row an integer tentative label. Its input is a stream of runs, one per clock at most. Each run carries a two-bit shape code that says where the run sits among the runs of its prefix component in the current row: alone, leftmost, between, or rightmost. Runs of one component in a row leave the block with the same label. Runs of different components get different labels. No equivalence table and no second pass are used. The shape codes nest like brackets, so a small label stack is enough to resolve them: a leftmost run opens a bracket and a rightmost run closes it.

A fresh-label counter restarts at 1 on every row. The row ends with a marker, which may come with the row's last run or on a cycle of its own. The marker empties the stack and rearms the counter. The label leaves the block one clock after its run, together with a valid bit. Three one-clock flags report protocol faults:
- a middle or rightmost code that finds no open component,
- a leftmost code that finds the stack already full,
- a row that ends with components still open.

Top module: `run_label_assigner`

## Requirements
- R1: While reset is held, and after it is released, `lbl_vld`, `lbl_out`, `err_empty`, `err_full` and `err_open` are all 0.
- R2: A run with code 0 (single) takes the current fresh label. The fresh label then advances by one.
- R3: A run with code 1 (leftmost) takes the current fresh label and pushes it onto the stack. The fresh label then advances by one.
- R4: A run with code 2 (middle) takes the label on top of the stack and leaves the stack unchanged.
- R5: A run with code 3 (rightmost) takes the label on top of the stack and then pops it.
- R6: The first fresh label of every row is 1. Only codes 0 and 1 advance the fresh label.
- R7: The result of a run accepted at one rising edge appears at the next edge, and one run can be accepted every clock. `lbl_vld` is high exactly in the cycles that follow an accepted run.
- R8: The row-end marker empties the stack and sets the fresh label back to 1 for the next row. A run that arrives together with the marker is still labeled from the state before the marker.
- R9: `err_open` pulses, aligned with the outputs of the marker's cycle, when the stack is not empty after the run of that cycle has been handled.
- R10: A code 2 or code 3 run that arrives with an empty stack raises `err_empty`. Its label is 0 and the stack is left unchanged.
- R11: A code 1 run that arrives with `DEPTH` entries already on the stack still takes a fresh label. Its push is dropped and `err_full` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_vld | input | 1 | A run is presented this cycle |
| run_code | input | 2 | Shape code: 0 single, 1 leftmost, 2 middle, 3 rightmost |
| row_end | input | 1 | Current row ends after this cycle |
| lbl_vld | output | 1 | `lbl_out` holds a new label |
| lbl_out | output | LBL_W | Tentative label of the run |
| err_empty | output | 1 | Middle or rightmost code with an empty stack |
| err_full | output | 1 | Leftmost code with a full stack (push dropped) |
| err_open | output | 1 | Row ended with open components |

## Verification
The hardest state to reach is a full stack. It takes `DEPTH` leftmost runs in one row with no close in between, and ordinary bracket-balanced rows almost never nest that deep. So a directed row opens one component more than the stack holds and then unwinds all of them. This checks that the dropped push keeps the labels on the way back down intact. Two more cases only show up across row boundaries: a marker that ends a row while components are still open, and a row marker that comes with no run. These are driven on purpose and then followed by a new row that starts with a middle code. Random bracket-balanced rows and random unconstrained codes with idle gaps then run against a queue-based model on every clock.

// File: rtl/rla_pkg.sv
package rla_pkg;

  typedef enum logic [1:0] {
    SH_SINGLE = 2'd0,
    SH_OPEN   = 2'd1,
    SH_MID    = 2'd2,
    SH_CLOSE  = 2'd3
  } shape_e;

endpackage

// File: rtl/rla_fresh_ctr.sv
module rla_fresh_ctr #(
  parameter int LBL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [LBL_W-1:0] fresh
);

  localparam logic [LBL_W-1:0] FIRST_LBL = LBL_W'(1);

  logic [LBL_W-1:0] cnt_q;
  logic [LBL_W-1:0] cnt_d;
  logic             cnt_en;

  // Row end has priority: the next row always opens at label 1.
  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = FIRST_LBL;
    end else if (inc) begin
      cnt_d = cnt_q + FIRST_LBL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= FIRST_LBL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign fresh = cnt_q;

endmodule

// File: rtl/rla_stack.sv
module rla_stack #(
  parameter int LBL_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [LBL_W-1:0] push_data,
  output logic [LBL_W-1:0] top,
  output logic             empty,
  output logic             full,
  output logic             nonempty_after
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);
  localparam logic [SP_W-1:0] SP_ONE  = SP_W'(1);

  logic [SP_W-1:0]  sp_q;
  logic [SP_W-1:0]  sp_d;
  logic [SP_W-1:0]  fill_after;
  logic             sp_en;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;
  logic [LBL_W-1:0] mem_q [DEPTH];

  assign empty  = (sp_q == '0);
  assign full   = (sp_q == SP_FULL);
  assign rd_idx = IDX_W'(sp_q - SP_ONE);
  assign wr_idx = IDX_W'(sp_q);
  assign wr_en  = push & ~full;

  // Fill level once this cycle's operation has been applied, before a row clear.
  always_comb begin
    fill_after = sp_q;
    if (wr_en) begin
      fill_after = sp_q + SP_ONE;
    end else if (pop && !empty) begin
      fill_after = sp_q - SP_ONE;
    end
    sp_d  = clr ? '0 : fill_after;
    sp_en = clr | wr_en | (pop & ~empty);
  end

  assign nonempty_after = (fill_after != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  // Label storage: no reset, only entries below the pointer are ever read.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_idx] <= push_data;
    end
  end

  assign top = empty ? '0 : mem_q[rd_idx];

endmodule

// File: rtl/rla_ctrl.sv
module rla_ctrl
  import rla_pkg::*;
#(
  parameter int LBL_W = 8
) (
  input  logic             run_vld,
  input  shape_e           shape,
  input  logic             stk_empty,
  input  logic             stk_full,
  input  logic [LBL_W-1:0] stk_top,
  input  logic [LBL_W-1:0] fresh_lbl,
  output logic [LBL_W-1:0] lbl,
  output logic             push,
  output logic             pop,
  output logic             take_fresh,
  output logic             bad_empty,
  output logic             bad_full
);

  always_comb begin
    lbl        = '0;
    push       = 1'b0;
    pop        = 1'b0;
    take_fresh = 1'b0;
    bad_empty  = 1'b0;
    bad_full   = 1'b0;
    if (run_vld) begin
      unique case (shape)
        SH_SINGLE: begin
          lbl        = fresh_lbl;
          take_fresh = 1'b1;
        end
        SH_OPEN: begin
          lbl        = fresh_lbl;
          take_fresh = 1'b1;
          push       = ~stk_full;
          bad_full   = stk_full;
        end
        SH_MID: begin
          lbl       = stk_top;
          bad_empty = stk_empty;
        end
        SH_CLOSE: begin
          lbl       = stk_top;
          pop       = ~stk_empty;
          bad_empty = stk_empty;
        end
        default: begin
          lbl = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/run_label_assigner.sv
module run_label_assigner
  import rla_pkg::*;
#(
  parameter int LBL_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_vld,
  input  logic [1:0]       run_code,
  input  logic             row_end,
  output logic             lbl_vld,
  output logic [LBL_W-1:0] lbl_out,
  output logic             err_empty,
  output logic             err_full,
  output logic             err_open
);

  shape_e           shape;
  logic [LBL_W-1:0] fresh_lbl;
  logic [LBL_W-1:0] stk_top;
  logic             stk_empty;
  logic             stk_full;
  logic             stk_left;
  logic [LBL_W-1:0] run_lbl;
  logic             do_push;
  logic             do_pop;
  logic             take_fresh;
  logic             bad_empty;
  logic             bad_full;

  logic             vld_q, vld_d;
  logic [LBL_W-1:0] lbl_q, lbl_d;
  logic             lbl_en;
  logic             e_empty_q, e_empty_d;
  logic             e_full_q, e_full_d;
  logic             e_open_q, e_open_d;

  assign shape = shape_e'(run_code);

  rla_fresh_ctr #(
    .LBL_W (LBL_W)
  ) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (row_end),
    .inc   (take_fresh),
    .fresh (fresh_lbl)
  );

  rla_stack #(
    .LBL_W (LBL_W),
    .DEPTH (DEPTH)
  ) u_stk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (row_end),
    .push           (do_push),
    .pop            (do_pop),
    .push_data      (fresh_lbl),
    .top            (stk_top),
    .empty          (stk_empty),
    .full           (stk_full),
    .nonempty_after (stk_left)
  );

  rla_ctrl #(
    .LBL_W (LBL_W)
  ) u_ctrl (
    .run_vld    (run_vld),
    .shape      (shape),
    .stk_empty  (stk_empty),
    .stk_full   (stk_full),
    .stk_top    (stk_top),
    .fresh_lbl  (fresh_lbl),
    .lbl        (run_lbl),
    .push       (do_push),
    .pop        (do_pop),
    .take_fresh (take_fresh),
    .bad_empty  (bad_empty),
    .bad_full   (bad_full)
  );

  // Output stage next state.
  always_comb begin
    vld_d     = run_vld;
    lbl_en    = run_vld;
    lbl_d     = run_lbl;
    e_empty_d = bad_empty;
    e_full_d  = bad_full;
    e_open_d  = row_end & stk_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      e_empty_q <= 1'b0;
      e_full_q  <= 1'b0;
      e_open_q  <= 1'b0;
    end else begin
      vld_q     <= vld_d;
      e_empty_q <= e_empty_d;
      e_full_q  <= e_full_d;
      e_open_q  <= e_open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbl_q <= '0;
    end else if (lbl_en) begin
      lbl_q <= lbl_d;
    end
  end

  assign lbl_vld   = vld_q;
  assign lbl_out   = lbl_q;
  assign err_empty = e_empty_q;
  assign err_full  = e_full_q;
  assign err_open  = e_open_q;

endmodule

// File: rtl/rla_checker.sv
module rla_checker #(
  parameter int LBL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_vld,
  input logic [1:0]       run_code,
  input logic             row_end,
  input logic             lbl_vld,
  input logic [LBL_W-1:0] lbl_out,
  input logic             err_empty,
  input logic             err_full,
  input logic             err_open
);

  // R7
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_vld |=> lbl_vld);

  // R7
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_vld |=> !lbl_vld);

  // R10
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_empty |-> (lbl_vld && lbl_out == '0));

  // R11
  full_with_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_full |-> (lbl_vld && !err_empty));

  // R9
  open_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_end |=> !err_open);

  // R6
  row_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end ##1 (run_vld && run_code[1] == 1'b0)) |=> (lbl_out == LBL_W'(1)));

endmodule

bind run_label_assigner rla_checker #(.LBL_W(LBL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_vld   (run_vld),
  .run_code  (run_code),
  .row_end   (row_end),
  .lbl_vld   (lbl_vld),
  .lbl_out   (lbl_out),
  .err_empty (err_empty),
  .err_full  (err_full),
  .err_open  (err_open)
);

// File: tb/run_label_assigner_tb.sv
module run_label_assigner_tb;

  localparam int LBL_W = 8;
  localparam int DEPTH = 8;

  logic             clk;
  logic             rst_n;
  logic             run_vld;
  logic [1:0]       run_code;
  logic             row_end;
  logic             lbl_vld;
  logic [LBL_W-1:0] lbl_out;
  logic             err_empty;
  logic             err_full;
  logic             err_open;

  int n_checks = 0;
  int n_fails  = 0;

  // Reference model state
  int stk[$];
  int fresh = 1;
  bit exp_vld = 0;
  int exp_lbl = 0;
  bit exp_empty = 0;
  bit exp_full = 0;
  bit exp_open = 0;
  string exp_tag = "R7";

  run_label_assigner #(.LBL_W(LBL_W), .DEPTH(DEPTH)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_vld   (run_vld),
    .run_code  (run_code),
    .row_end   (row_end),
    .lbl_vld   (lbl_vld),
    .lbl_out   (lbl_out),
    .err_empty (err_empty),
    .err_full  (err_full),
    .err_open  (err_open)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R7", int'(lbl_vld), int'(exp_vld));
    if (exp_vld) check(exp_tag, int'(lbl_out), exp_lbl);
    check("R10", int'(err_empty), int'(exp_empty));
    check("R11", int'(err_full), int'(exp_full));
    check("R9", int'(err_open), int'(exp_open));
  endtask

  // One cycle: check results of the previous input, then present a new one.
  task automatic step(input bit v, input int code, input bit e, input string tag);
    @(negedge clk);
    compare();
    run_vld  = v;
    run_code = 2'(code);
    row_end  = e;
    exp_vld = v; exp_lbl = 0; exp_empty = 0; exp_full = 0; exp_open = 0;
    exp_tag = tag;
    if (v) begin
      case (code)
        0: begin exp_lbl = fresh; fresh++; end
        1: begin
          exp_lbl = fresh; fresh++;
          if (stk.size() < DEPTH) stk.push_back(exp_lbl); else exp_full = 1;
        end
        2: begin
          if (stk.size() == 0) exp_empty = 1; else exp_lbl = stk[$];
        end
        default: begin
          if (stk.size() == 0) exp_empty = 1; else exp_lbl = stk.pop_back();
        end
      endcase
    end
    if (e) begin
      if (stk.size() != 0) exp_open = 1;
      stk.delete();
      fresh = 1;
    end
  endtask

  function automatic string code_tag(input int code);
    case (code)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; run_vld = 1'b0; run_code = 2'd0; row_end = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(lbl_vld), 0);
    check("R1", int'(lbl_out), 0);
    check("R1", int'({err_empty, err_full, err_open}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'({lbl_vld, err_empty, err_full, err_open}), 0);

    // Plain row: S L M R S -> 1 2 2 2 3
    step(1, 0, 0, "R2"); step(1, 1, 0, "R3"); step(1, 2, 0, "R4");
    step(1, 3, 0, "R5"); step(1, 0, 1, "R8");
    // New row restarts at 1
    step(1, 0, 0, "R6"); step(1, 0, 1, "R6");
    // Nested with idle gaps: L L M R R -> 1 2 2 2 1
    step(1, 1, 0, "R3"); step(0, 0, 0, "R7"); step(1, 1, 0, "R3");
    step(1, 2, 0, "R4"); step(0, 0, 0, "R7"); step(1, 3, 0, "R5");
    step(1, 3, 1, "R5");
    // Open component at row end, marker without run
    step(1, 1, 0, "R3"); step(1, 0, 0, "R2"); step(0, 0, 1, "R9");
    // Stack was emptied: middle code now underflows
    step(1, 2, 0, "R8"); step(1, 0, 0, "R6");
    step(1, 3, 1, "R10");
    // Stack overflow: DEPTH+1 opens, then unwind
    for (int i = 0; i <= DEPTH; i++) step(1, 1, 0, "R11");
    for (int i = 0; i < DEPTH; i++) step(1, 3, (i == DEPTH - 1), "R11");
    step(1, 0, 1, "R6");

    // Random bracket-balanced rows
    for (int r = 0; r < 300; r++) begin
      int depth = 0;
      int len = 2 + ($urandom % 24);
      for (int i = 0; i < len; i++) begin
        int c;
        bit last = (i == len - 1) && (depth <= 1);
        if (depth == 0) c = $urandom % 2;
        else if (depth >= DEPTH) c = 2 + ($urandom % 2);
        else c = $urandom % 4;
        if (last && depth == 1) c = 3;
        else if (last) c = 0;
        if (c == 1) depth++;
        if (c == 3) depth--;
        if ($urandom % 5 == 0) step(0, 0, 0, "R7");
        step(1, c, last, code_tag(c));
      end
      while (depth > 0) begin
        depth--;
        step(1, 3, depth == 0, "R5");
      end
    end

    // Unconstrained codes, idle cycles and row ends
    for (int i = 0; i < 3000; i++) begin
      int c = $urandom % 4;
      bit v = ($urandom % 4) != 0;
      bit e = ($urandom % 12) == 0;
      step(v, c, e, e ? "R8" : code_tag(c));
    end
    step(0, 0, 1, "R9");
    step(0, 0, 0, "R7");
    step(0, 0, 0, "R7");
    summary();
  end

endmodule